// File: doc/BRIEF.md
# Credit-Based Transmit Flow Gate

This block sits on the outbound side of one virtual channel of a serial packet link. It holds back each outbound packet until the link partner has advertised enough free receive-buffer space for it. There are three traffic categories, each with its own pool: posted, non-posted and completion. Each pool holds a header-credit budget and a data-credit budget. One data credit stands for four doublewords of payload. Credit messages reach the gate already parsed and CRC-checked. Each message names its kind, its category, a header credit value and a data credit value.

After reset the gate starts the initialisation handshake for the default channel by itself, with no software action. It first collects a first-phase message for all three categories, and those messages set the starting limits. It then collects a second-phase message for all three categories, and only then does it declare the channel ready. From that point, periodic update messages replace the stored limits as absolute values. A lost update therefore does no lasting harm. The gate keeps a running count of the credits it has consumed in each pool. It grants a request in the same cycle when the stored limit minus the consumed count, taken modulo the counter width, covers what the request needs.

Top module: `credit_tx_gate`

## Requirements
- R1: While reset is asserted, `grant` and `link_ready` are 0.
- R2: No request is granted while `link_ready` is 0, even one that needs zero credits.
- R3: Message kinds are encoded as 0 = first-phase init, 1 = second-phase init, 2 = update, 3 = ignored. Categories are encoded as 0 = posted, 1 = non-posted, 2 = completion. `link_ready` rises on the clock edge that completes the set of second-phase messages for all three categories. That set is only collected after first-phase messages have been seen for all three categories. A second-phase message received earlier is ignored, repeats within a phase are harmless, and once `link_ready` is 1 it stays 1 until reset.
- R4: Update messages received before `link_ready` is 1 leave the limits unchanged, and so do first-phase messages received after the first phase has ended.
- R5: `grant` is 1 in the same cycle as a valid request of category c exactly when `link_ready` is 1 and both of these hold. First, c's header limit minus c's header consumed count, modulo 256, is at least `req_hdr`. Second, the same difference for data, modulo 4096, is at least `req_data`.
- R6: On each clock edge where `grant` is 1, the requested header and data credits are added to the consumed counts of the requested category. The counts change on no other edge.
- R7: A header or data value of 0 in a category's first-phase message makes that field unlimited. That field never blocks a request, and later updates to that field are ignored.
- R8: An update message replaces the category's finite limits with the carried values as absolute values. Repeating the same update therefore adds no credit.
- R9: Each category's limits and counts are unaffected by messages and grants of the other categories.
- R10: Limit and consumed arithmetic wraps modulo the counter width, so grants stay correct after the counts pass 255 (header) or 4095 (data).
- R11: A request or message with category code 3 is never granted and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc_valid | input | 1 | A credit message is present this cycle |
| fc_kind | input | 2 | Message kind: 0 init phase one, 1 init phase two, 2 update |
| fc_cat | input | 2 | Message category: 0 posted, 1 non-posted, 2 completion |
| fc_hdr | input | 8 | Header credit value carried by the message |
| fc_data | input | 12 | Data credit value carried by the message |
| req_valid | input | 1 | An outbound packet asks to leave this cycle |
| req_cat | input | 2 | Category of the requesting packet |
| req_hdr | input | 8 | Header credits the packet needs |
| req_data | input | 12 | Data credits the packet needs |
| grant | output | 1 | The packet may leave; its credits are consumed at this edge |
| link_ready | output | 1 | Initialisation is complete |

## Verification
The hardest state to reach from the ports is a consumed count that has wrapped past its counter width while the limit is still a small number just ahead of it. Reaching that state takes hundreds of granted packets, each one fed by a fresh update. The bench repeatedly advertises a limit a fixed step ahead of its own model of the consumed count, and it requests exactly that step. This carries the header count through several wraps, and the bench also probes one credit beyond the step. A long arithmetic sweep mixes categories, including the invalid code, with request sizes and absolute updates, and it compares every cycle against a model kept in the bench.

// File: rtl/credit_tx_gate.sv
`timescale 1ns/1ps
module credit_tx_gate #(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12,
  parameter int NCAT   = 3,
  parameter int CAT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_valid,
  input  logic [1:0]        fc_kind,
  input  logic [CAT_W-1:0]  fc_cat,
  input  logic [HDR_W-1:0]  fc_hdr,
  input  logic [DATA_W-1:0] fc_data,
  input  logic              req_valid,
  input  logic [CAT_W-1:0]  req_cat,
  input  logic [HDR_W-1:0]  req_hdr,
  input  logic [DATA_W-1:0] req_data,
  output logic              grant,
  output logic              link_ready
);
  localparam logic [1:0] K_INIT1 = 2'd0;
  localparam logic [1:0] K_INIT2 = 2'd1;
  localparam logic [1:0] K_UPD   = 2'd2;
  localparam logic [1:0] PH_ONE  = 2'd0;
  localparam logic [1:0] PH_TWO  = 2'd1;
  localparam logic [1:0] PH_RUN  = 2'd2;

  logic [1:0] phase;
  logic [NCAT-1:0] seen1, seen2, hit_fc, hit_req, fits, hinf, dinf;
  logic [NCAT-1:0][HDR_W-1:0]  hlim, hcons;
  logic [NCAT-1:0][DATA_W-1:0] dlim, dcons;

  assign link_ready = (phase == PH_RUN);
  assign grant      = req_valid && link_ready && |(hit_req & fits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_ONE;
      seen1 <= '0;
      seen2 <= '0;
    end else begin
      case (phase)
        PH_ONE: if (fc_kind == K_INIT1) begin
          seen1 <= seen1 | hit_fc;
          if (&(seen1 | hit_fc)) phase <= PH_TWO;
        end
        PH_TWO: if (fc_kind == K_INIT2) begin
          seen2 <= seen2 | hit_fc;
          if (&(seen2 | hit_fc)) phase <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NCAT; c++) begin : g_pool
    logic [HDR_W-1:0]  havail;
    logic [DATA_W-1:0] davail;
    assign hit_fc[c]  = fc_valid && (fc_cat == CAT_W'(c));
    assign hit_req[c] = (req_cat == CAT_W'(c));
    assign havail     = hlim[c] - hcons[c];
    assign davail     = dlim[c] - dcons[c];
    assign fits[c]    = (hinf[c] || havail >= req_hdr) && (dinf[c] || davail >= req_data);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hlim[c]  <= '0;
        dlim[c]  <= '0;
        hinf[c]  <= 1'b0;
        dinf[c]  <= 1'b0;
        hcons[c] <= '0;
        dcons[c] <= '0;
      end else begin
        if (hit_fc[c] && fc_kind == K_INIT1 && phase == PH_ONE) begin
          hlim[c] <= fc_hdr;
          dlim[c] <= fc_data;
          hinf[c] <= (fc_hdr == '0);
          dinf[c] <= (fc_data == '0);
        end else if (hit_fc[c] && fc_kind == K_UPD && phase == PH_RUN) begin
          if (!hinf[c]) hlim[c] <= fc_hdr;
          if (!dinf[c]) dlim[c] <= fc_data;
        end
        if (grant && hit_req[c]) begin
          hcons[c] <= hcons[c] + req_hdr;
          dcons[c] <= dcons[c] + req_data;
        end
      end
    end
  end
endmodule

module credit_tx_gate_chk #(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12,
  parameter int NCAT   = 3,
  parameter int CAT_W  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fc_valid,
  input logic [1:0]               fc_kind,
  input logic                     req_valid,
  input logic [CAT_W-1:0]         req_cat,
  input logic                     grant,
  input logic                     link_ready,
  input logic [NCAT*HDR_W-1:0]    hlim,
  input logic [NCAT*HDR_W-1:0]    hcons,
  input logic [NCAT*DATA_W-1:0]   dlim,
  input logic [NCAT*DATA_W-1:0]   dcons
);
  assert_no_grant_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ready |-> !grant);
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |=> link_ready);
  assert_ready_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(fc_valid && fc_kind == 2'd1));
  assert_grant_valid_cat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (req_valid && req_cat < CAT_W'(NCAT)));
  assert_cons_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> ($stable(hcons) && $stable(dcons)));
  assert_limit_by_msg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(hlim) && $stable(dlim)) |-> $past(fc_valid));
endmodule

bind credit_tx_gate credit_tx_gate_chk #(
  .HDR_W(HDR_W), .DATA_W(DATA_W), .NCAT(NCAT), .CAT_W(CAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_valid(fc_valid), .fc_kind(fc_kind),
  .req_valid(req_valid), .req_cat(req_cat), .grant(grant), .link_ready(link_ready),
  .hlim(hlim), .hcons(hcons), .dlim(dlim), .dcons(dcons)
);

// File: tb/tb_credit_tx_gate.sv
`timescale 1ns/1ps
module tb_credit_tx_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fc_valid = 1'b0, req_valid = 1'b0;
  logic [1:0] fc_kind = '0, fc_cat = '0, req_cat = '0;
  logic [7:0] fc_hdr = '0, req_hdr = '0;
  logic [11:0] fc_data = '0, req_data = '0;
  logic grant, link_ready;

  int checks = 0, errors = 0;
  int mphase = 0, mseen1 = 0, mseen2 = 0;
  int mhlim[3], mdlim[3], mhcons[3], mdcons[3];
  bit mhinf[3], mdinf[3];

  always #2.5 clk = ~clk;

  credit_tx_gate dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit fv, input int fk, input int fc, input int fh, input int fd,
                      input bit rv, input int rc, input int rh, input int rd, input string tag);
    bit eg;
    @(negedge clk);
    fc_valid = fv; fc_kind = fk[1:0]; fc_cat = fc[1:0]; fc_hdr = fh[7:0]; fc_data = fd[11:0];
    req_valid = rv; req_cat = rc[1:0]; req_hdr = rh[7:0]; req_data = rd[11:0];
    #1;
    eg = 1'b0;
    if (rv && mphase == 2 && rc < 3)
      eg = (mhinf[rc] || (((mhlim[rc] - mhcons[rc]) & 255) >= rh)) &&
           (mdinf[rc] || (((mdlim[rc] - mdcons[rc]) & 4095) >= rd));
    check(grant === eg, tag, int'(grant), int'(eg));
    check(link_ready === (mphase == 2), "R3 ready", int'(link_ready), int'(mphase == 2));
    if (eg) begin
      mhcons[rc] = (mhcons[rc] + rh) & 255;
      mdcons[rc] = (mdcons[rc] + rd) & 4095;
    end
    if (fv && fc < 3) begin
      if (mphase == 0 && fk == 0) begin
        mhlim[fc] = fh; mdlim[fc] = fd;
        mhinf[fc] = (fh == 0); mdinf[fc] = (fd == 0);
        mseen1 |= (1 << fc);
        if (mseen1 == 7) mphase = 1;
      end else if (mphase == 1 && fk == 1) begin
        mseen2 |= (1 << fc);
        if (mseen2 == 7) mphase = 2;
      end else if (mphase == 2 && fk == 2) begin
        if (!mhinf[fc]) mhlim[fc] = fh;
        if (!mdinf[fc]) mdlim[fc] = fd;
      end
    end
  endtask

  task automatic req(input int rc, input int rh, input int rd, input string tag);
    step(0, 0, 0, 0, 0, 1, rc, rh, rd, tag);
  endtask

  task automatic msg(input int fk, input int fc, input int fh, input int fd, input string tag);
    step(1, fk, fc, fh, fd, 1, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      mhlim[i] = 0; mdlim[i] = 0; mhcons[i] = 0; mdcons[i] = 0; mhinf[i] = 0; mdinf[i] = 0;
    end
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(grant === 1'b0, "R1 grant in reset", int'(grant), 0);
    check(link_ready === 1'b0, "R1 ready in reset", int'(link_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;

    req(0, 0, 0, "R2 zero need before init");
    msg(2, 0, 100, 100, "R4 update before init");
    msg(1, 0, 0, 0, "R3 phase two too early");
    msg(0, 2, 3, 0, "R2 during phase one");
    msg(0, 3, 9, 9, "R11 bad category message");
    msg(0, 0, 4, 16, "R2 during phase one");
    msg(0, 0, 4, 16, "R3 repeated phase one");
    msg(0, 1, 0, 2, "R3 last phase one");
    msg(0, 0, 200, 200, "R4 phase one after phase one");
    msg(2, 0, 100, 100, "R4 update in phase two");
    msg(1, 1, 9, 9, "R3 phase two");
    msg(1, 1, 9, 9, "R3 repeated phase two");
    msg(1, 2, 9, 9, "R2 during phase two");
    req(0, 0, 0, "R2 zero need in phase two");
    msg(1, 0, 9, 9, "R3 last phase two");

    req(0, 4, 16, "R4 init limit honoured");
    req(0, 1, 0, "R5 header exhausted");
    msg(2, 0, 6, 16, "R8 update");
    msg(2, 0, 6, 16, "R8 repeated update");
    req(0, 3, 0, "R8 no added credit");
    req(0, 2, 0, "R6 exact fit");
    req(0, 1, 0, "R6 consumed after grant");
    req(1, 200, 2, "R7 unlimited header");
    msg(2, 1, 1, 2, "R7 update to unlimited header");
    req(1, 50, 0, "R7 header still unlimited");
    req(1, 0, 1, "R7 finite data blocks");
    req(2, 3, 4000, "R9 completion pool untouched");
    req(2, 1, 1, "R9 completion header exhausted");
    req(3, 0, 0, "R11 bad category request");

    for (int k = 0; k < 300; k++) begin
      msg(2, 0, (mhcons[0] + 5) & 255, (mdcons[0] + 20) & 4095, "R10 advertise");
      req(0, 6, 0, "R10 one beyond step");
      req(0, 5, 20, "R10 step across wrap");
    end

    for (int i = 0; i < 2500; i++) begin
      int c, h, d;
      c = (i * 37 + 11) % 4;
      h = (i * 7) % 6;
      d = (i * 13) % 40;
      if (i % 5 == 0)
        step(1, 2, (i * 3) % 4, (mhcons[(i * 3) % 3] + i % 9) & 255,
             (mdcons[(i * 3) % 3] + (i * 11) % 50) & 4095, 1, c, h, d, "R5 sweep with update");
      else
        step(0, 0, 0, 0, 0, 1, c, h, d, "R5 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule